// File: doc/BRIEF.md
# LED Gradual Dimming Sequencer

This block moves a 5-bit peak-current index from its present value to a programmed end value, one step at a time. Each step lasts a programmable period. The period is a binary multiple of 8 ms, paced by an external 1 ms tick. Software holds two end values, one for upward ramps and one for downward ramps. Whichever of the two was written last sets the direction of the next ramp. Writing the step-time code loads the period and starts the ramp in the same action. The block converts no index to an analog current and produces no LED PWM.

The index moves in one direction only and wraps modulo 32. An upward ramp whose target lies below the start climbs to 31, rolls over to 0, then climbs to the target. A downward ramp whose target lies above the start does the mirror of this. The number of steps is the distance from start to target in the chosen direction, and the ramp lasts that many step periods.

A shutdown command or a synchronous reset aborts a ramp and clears the index to zero. A start request that arrives during a ramp is dropped.

Top module: `led_dim_sequencer`

## Requirements
- R1: While idle, a pulse on `idx_wr_i` loads `idx_wdata_i` into `idx_o` at the next clock edge. While `busy_o` is high, index writes have no effect.
- R2: A start (`time_wr_i` while idle) with a nonzero code and a target different from the index raises `busy_o` at the next edge. The index then holds for code×8−1 ticks and changes on tick number code×8. The step-time code is 5 bits with weights 8, 16, 32, 64 and 128 ms from bit 0 to bit 4.
- R3: A ramp counts upward if the upward target (`up_wr_i`) was written more recently than the downward target (`dn_wr_i`), and downward otherwise. After reset the upward direction is selected and both targets are 0.
- R4: The ramp takes as many steps as the distance to the target. `busy_o` falls on the same edge at which `idx_o` reaches the target.
- R5: On an upward ramp whose target is below the start, the index counts up to 31, steps to 0, then counts up to the target.
- R6: On a downward ramp whose target is above the start, the index counts down to 0, steps to 31, then counts down to the target.
- R7: A start request that arrives while busy is ignored: the ramp keeps its period, direction and target.
- R8: A start with code 0 loads the selected target into `idx_o` at the next edge, and `busy_o` stays low.
- R9: `shutdown_i` or `rst` clears `idx_o` to 0 and `busy_o` to 0 at the next edge, aborting any ramp. Ticks after that do not move the index.
- R10: Each change of `idx_o` during a ramp is a single step of +1 or −1 modulo 32. The index never changes between ticks.
- R11: A start whose selected target equals the present index leaves `busy_o` low and the index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| shutdown_i | input | 1 | Abort the ramp and clear the index |
| idx_wr_i | input | 1 | Direct index write strobe |
| idx_wdata_i | input | 5 | Index value for a direct write |
| up_wr_i | input | 1 | Upward target write strobe |
| dn_wr_i | input | 1 | Downward target write strobe |
| tgt_wdata_i | input | 5 | Target value for either target write |
| time_wr_i | input | 1 | Step-time write strobe; also starts the ramp |
| time_code_i | input | 5 | Step-time code, in units of 8 ms |
| tick_ms_i | input | 1 | 1 ms timebase pulse, one clock wide |
| idx_o | output | 5 | Live current index |
| busy_o | output | 1 | Ramp in progress |

## Verification
The assertions assume that every strobe, including `tick_ms_i`, is at most one clock wide. They also assume that `up_wr_i` and `dn_wr_i` are never raised in the same cycle, and that reset is held for at least one edge before any command arrives. The directed stimulus drives each command as a single-cycle pulse placed after a clock edge. It issues at most one command per cycle and never issues a target write together with a start. Ticks run back to back, so every step boundary falls on an exact tick count that the bench can predict.

// File: rtl/led_dim_sequencer.sv
module led_dim_sequencer #(
  parameter int IDX_W      = 5,
  parameter int CODE_W     = 5,
  parameter int TICK_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shutdown_i,
  input  logic              idx_wr_i,
  input  logic [IDX_W-1:0]  idx_wdata_i,
  input  logic              up_wr_i,
  input  logic              dn_wr_i,
  input  logic [IDX_W-1:0]  tgt_wdata_i,
  input  logic              time_wr_i,
  input  logic [CODE_W-1:0] time_code_i,
  input  logic              tick_ms_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              busy_o
);
  localparam int CNT_W = CODE_W + TICK_SHIFT;

  logic [IDX_W-1:0] idx_q, up_q, dn_q, tgt_q;
  logic             busy_q, dir_up_q, run_up_q;
  logic [CNT_W-1:0] per_q, cnt_q;

  wire              start    = time_wr_i && !busy_q;
  wire [IDX_W-1:0]  sel_tgt  = dir_up_q ? up_q : dn_q;
  wire [IDX_W-1:0]  idx_next = run_up_q ? idx_q + 1'b1 : idx_q - 1'b1;
  wire              last_ms  = cnt_q == per_q - 1'b1;
  wire [CNT_W-1:0]  new_per  = {time_code_i, {TICK_SHIFT{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= '0;
      up_q     <= '0;
      dn_q     <= '0;
      tgt_q    <= '0;
      busy_q   <= 1'b0;
      dir_up_q <= 1'b1;
      run_up_q <= 1'b1;
      per_q    <= '0;
      cnt_q    <= '0;
    end else begin
      if (up_wr_i) begin
        up_q     <= tgt_wdata_i;
        dir_up_q <= 1'b1;
      end
      if (dn_wr_i) begin
        dn_q     <= tgt_wdata_i;
        dir_up_q <= 1'b0;
      end

      if (shutdown_i) begin
        idx_q  <= '0;
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (tick_ms_i) begin
          if (last_ms) begin
            cnt_q <= '0;
            idx_q <= idx_next;
            if (idx_next == tgt_q) busy_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end else if (start) begin
        if (time_code_i == '0 || sel_tgt == idx_q) begin
          idx_q <= sel_tgt;
        end else begin
          busy_q   <= 1'b1;
          tgt_q    <= sel_tgt;
          run_up_q <= dir_up_q;
          per_q    <= new_per;
          cnt_q    <= '0;
        end
      end else if (idx_wr_i) begin
        idx_q <= idx_wdata_i;
      end
    end
  end

  assign idx_o  = idx_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/led_dim_sequencer_chk.sv
module led_dim_sequencer_chk #(
  parameter int IDX_W  = 5,
  parameter int CODE_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              shutdown_i,
  input logic              idx_wr_i,
  input logic              time_wr_i,
  input logic [CODE_W-1:0] time_code_i,
  input logic              tick_ms_i,
  input logic [IDX_W-1:0]  idx_o,
  input logic              busy_o
);
  p_abort_r9: assert property (@(posedge clk) disable iff (rst)
    $past(shutdown_i) |-> (idx_o == '0 && !busy_o));

  p_single_step_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(busy_o) && !$past(shutdown_i) && !$past(rst) && idx_o != $past(idx_o))
      |-> (idx_o == $past(idx_o) + 1'b1 || idx_o == $past(idx_o) - 1'b1));

  p_hold_between_ticks_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(busy_o) && !$past(tick_ms_i) && !$past(shutdown_i) && !$past(rst))
      |-> $stable(idx_o));

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(busy_o) && !$past(idx_wr_i) && !$past(time_wr_i) && !$past(shutdown_i) && !$past(rst))
      |-> $stable(idx_o));

  p_busy_from_start_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> ($past(time_wr_i) && $past(time_code_i) != '0));

  p_zero_code_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(time_wr_i) && !$past(busy_o) && $past(time_code_i) == '0 && !$past(rst))
      |-> !busy_o);
endmodule

bind led_dim_sequencer led_dim_sequencer_chk #(.IDX_W(IDX_W), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .shutdown_i(shutdown_i), .idx_wr_i(idx_wr_i),
  .time_wr_i(time_wr_i), .time_code_i(time_code_i), .tick_ms_i(tick_ms_i),
  .idx_o(idx_o), .busy_o(busy_o)
);

// File: tb/tb_led_dim_sequencer.sv
module tb_led_dim_sequencer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       shutdown_i = 1'b0;
  logic       idx_wr_i = 1'b0;
  logic [4:0] idx_wdata_i = '0;
  logic       up_wr_i = 1'b0;
  logic       dn_wr_i = 1'b0;
  logic [4:0] tgt_wdata_i = '0;
  logic       time_wr_i = 1'b0;
  logic [4:0] time_code_i = '0;
  logic       tick_ms_i = 1'b0;
  logic [4:0] idx_o;
  logic       busy_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  led_dim_sequencer dut (
    .clk(clk), .rst(rst), .shutdown_i(shutdown_i),
    .idx_wr_i(idx_wr_i), .idx_wdata_i(idx_wdata_i),
    .up_wr_i(up_wr_i), .dn_wr_i(dn_wr_i), .tgt_wdata_i(tgt_wdata_i),
    .time_wr_i(time_wr_i), .time_code_i(time_code_i),
    .tick_ms_i(tick_ms_i), .idx_o(idx_o), .busy_o(busy_o)
  );

  task automatic step_clk();
    @(posedge clk);
    #2;
  endtask

  task automatic check(string req, int act_idx, int exp_idx, bit act_b, bit exp_b);
    checks++;
    if (act_idx != exp_idx || act_b != exp_b) begin
      errors++;
      $display("FAIL %s: idx=%0d busy=%0b expected idx=%0d busy=%0b",
               req, act_idx, act_b, exp_idx, exp_b);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      tick_ms_i = 1'b1;
      step_clk();
      tick_ms_i = 1'b0;
    end
  endtask

  task automatic wr_idx(int v);
    idx_wr_i = 1'b1; idx_wdata_i = 5'(v); step_clk(); idx_wr_i = 1'b0;
  endtask

  task automatic wr_up(int v);
    up_wr_i = 1'b1; tgt_wdata_i = 5'(v); step_clk(); up_wr_i = 1'b0;
  endtask

  task automatic wr_dn(int v);
    dn_wr_i = 1'b1; tgt_wdata_i = 5'(v); step_clk(); dn_wr_i = 1'b0;
  endtask

  task automatic wr_time(int c);
    time_wr_i = 1'b1; time_code_i = 5'(c); step_clk(); time_wr_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R9 reset state", idx_o, 0, busy_o, 1'b0);
  endtask

  task automatic t_basic_up();
    wr_idx(5);
    check("R1 idle index write", idx_o, 5, busy_o, 1'b0);
    wr_up(8);
    wr_time(1);
    check("R2 busy after start", idx_o, 5, busy_o, 1'b1);
    tick(7);
    check("R2 hold for 7 ticks", idx_o, 5, busy_o, 1'b1);
    tick(1);
    check("R2 step on tick 8", idx_o, 6, busy_o, 1'b1);
    tick(15);
    check("R4 one step short", idx_o, 7, busy_o, 1'b1);
    tick(1);
    check("R4 land and clear busy", idx_o, 8, busy_o, 1'b0);
  endtask

  task automatic t_down_code2();
    wr_up(20);
    wr_dn(3);
    wr_time(2);
    tick(15);
    check("R2 code 2 holds 15 ticks", idx_o, 8, busy_o, 1'b1);
    tick(1);
    check("R3 last written selects down", idx_o, 7, busy_o, 1'b1);
    tick(64);
    check("R4 five steps down", idx_o, 3, busy_o, 1'b0);
  endtask

  task automatic t_up_wrap();
    wr_idx(29);
    wr_up(1);
    wr_time(1);
    tick(8);  check("R5 up to 30", idx_o, 30, busy_o, 1'b1);
    tick(8);  check("R5 up to 31", idx_o, 31, busy_o, 1'b1);
    tick(8);  check("R5 wrap to 0", idx_o, 0, busy_o, 1'b1);
    tick(8);  check("R5 land at 1", idx_o, 1, busy_o, 1'b0);
  endtask

  task automatic t_dn_wrap();
    wr_idx(2);
    wr_dn(30);
    wr_time(1);
    tick(8);  check("R6 down to 1", idx_o, 1, busy_o, 1'b1);
    tick(8);  check("R6 down to 0", idx_o, 0, busy_o, 1'b1);
    tick(8);  check("R6 wrap to 31", idx_o, 31, busy_o, 1'b1);
    tick(8);  check("R6 land at 30", idx_o, 30, busy_o, 1'b0);
  endtask

  task automatic t_busy_ignore();
    wr_idx(10);
    wr_up(12);
    wr_time(1);
    tick(4);
    wr_time(3);
    wr_idx(0);
    check("R1 index write ignored while busy", idx_o, 10, busy_o, 1'b1);
    tick(4);
    check("R7 restart ignored, period kept", idx_o, 11, busy_o, 1'b1);
    tick(8);
    check("R7 original target kept", idx_o, 12, busy_o, 1'b0);
    wr_idx(17);
    check("R1 write after run", idx_o, 17, busy_o, 1'b0);
  endtask

  task automatic t_zero_code();
    wr_up(25);
    wr_time(0);
    check("R8 code zero loads target", idx_o, 25, busy_o, 1'b0);
  endtask

  task automatic t_same_target();
    wr_time(1);
    check("R11 equal target no run", idx_o, 25, busy_o, 1'b0);
    tick(8);
    check("R11 ticks do nothing", idx_o, 25, busy_o, 1'b0);
  endtask

  task automatic t_abort();
    wr_idx(3);
    wr_up(9);
    wr_time(1);
    tick(8);
    check("R10 single step", idx_o, 4, busy_o, 1'b1);
    shutdown_i = 1'b1; step_clk(); shutdown_i = 1'b0;
    check("R9 shutdown aborts", idx_o, 0, busy_o, 1'b0);
    tick(16);
    check("R9 no motion after shutdown", idx_o, 0, busy_o, 1'b0);
    wr_idx(6);
    wr_time(1);
    tick(3);
    rst = 1'b1; step_clk(); rst = 1'b0;
    check("R9 reset aborts", idx_o, 0, busy_o, 1'b0);
    wr_idx(4);
    wr_time(1);
    check("R3 targets cleared by reset, up selected", idx_o, 4, busy_o, 1'b1);
    tick(8 * 28);
    check("R3 up wrap to zero target", idx_o, 0, busy_o, 1'b0);
  endtask

  initial begin
    repeat (3) step_clk();
    rst = 1'b0;
    step_clk();
    t_reset();
    t_basic_up();
    t_down_code2();
    t_up_wrap();
    t_dn_wrap();
    t_busy_ignore();
    t_zero_code();
    t_same_target();
    t_abort();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule